// File: doc/BRIEF.md
# NAND Command Word Sequencer

This block sits between a flash driver's request queue and a NAND transaction engine. Each accepted request carries an opcode, an optional column address, an optional page (row) address, the device's page and spare sizes, a chip-enable choice and the DMA and ECC options. From these the block builds the primary command word, the secondary (confirm and ECC) word, the transfer length, the DMA control word and the completion interrupt bit to wait on. It presents them together with a one-cycle `launch` pulse.

Two-phase operations are handled inside the block. A program-setup or erase-setup request is not launched. Its computed words are kept until the matching confirm opcode arrives, and then both go out in one launch. Reads on pages wider than the small-page limit get their confirm opcode added automatically. A spare-area read on such pages becomes an ordinary page read whose column is moved past the data area. After a launch the block stays busy and refuses requests until the engine reports completion.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, `launch`, `busy`, `dma_valid` and every output word are 0, and `req_ready` is 1.
- R2: Every launched primary word has bit 31 set, carries the issued opcode in bits 7:0, and has bit 19 equal to `chip_sel`.
- R3: Opcodes 0x00, 0x01, 0x05, 0x50, 0x70 and 0x90 set primary bit 26 (read). Program setup 0x80 sets primary bit 25 (write). No other opcode sets either bit.
- R4: Address cycles are counted as follows. The column counts 2 when page_size > 512 and 1 otherwise, and only when `req_has_col` is set. The row counts ROW_BYTES, and only when `req_has_page` is set. A nonzero count N is written to primary bits 30:27 as {1'b1, N-1}. A zero count leaves those bits 0.
- R5: ID read (0x90) and status (0x70) always use exactly one address cycle and a data length of 5.
- R6: For reads and program setup, `data_len` = page_size + spare_size − effective column, and `xfer_col` is the effective column. For all other opcodes `data_len` is 0.
- R7: With page_size > 512, a spare read (0x50) is issued as opcode 0x00 with effective column = column + page_size, and it receives the read confirm.
- R8: The secondary word is base | 0x100 | confirm. The confirm is 0x30 after an effective 0x00 read on pages > 512, and 0xE0 after 0x05. Otherwise the secondary word is 0. The base has bit 27 set (Reed-Solomon) and has bit 29 set when page_size is 2048.
- R9: 0x80 and 0x60 produce no launch and leave the block idle. A following 0x10 (after 0x80) or 0xD0 (after 0x60) launches the stored primary word, length, column and row, with secondary word base | 0x100 | confirm. Bit 30 is also set when the confirm is 0x10 and `ecc_auto` is 1.
- R10: Any accepted opcode other than its own confirm discards a pending setup. A confirm with nothing pending is launched as a plain command with no direction bits and no length.
- R11: `irq_wait` is bit 28 when `dma_en` is set and the launch reads; otherwise it is bit 31. `irq_clear` is 0x90000000 in the launch cycle. When `dma_en` is set and the launch reads or writes, `dma_valid` is 1 and `dma_word` = 0xC0000000 + `data_len`; otherwise both are 0.
- R12: After a launch, `busy` is 1 and `req_ready` is 0 until `done_in`. Requests made meanwhile produce no launch and leave the output words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_opcode | input | 8 | Flash opcode |
| req_column | input | LEN_W | Column address |
| req_has_col | input | 1 | Column address phase present |
| req_page | input | PAGE_W | Page (row) address |
| req_has_page | input | 1 | Row address phase present |
| page_size | input | LEN_W | Data bytes per page |
| spare_size | input | LEN_W | Spare bytes per page |
| chip_sel | input | 1 | Selects the second chip enable |
| ecc_auto | input | 1 | Request automatic ECC on program confirm |
| dma_en | input | 1 | Transfers go through DMA |
| done_in | input | 1 | Completion reported by the engine |
| launch | output | 1 | One-cycle start strobe |
| busy | output | 1 | Transaction in flight |
| cmd_word | output | 32 | Primary command word |
| sec_word | output | 32 | Secondary confirm/ECC word |
| data_len | output | LEN_W | Transfer length |
| xfer_col | output | LEN_W | Effective column address |
| xfer_row | output | PAGE_W | Row address |
| dma_valid | output | 1 | DMA control word is in use |
| dma_word | output | 32 | DMA control word |
| irq_wait | output | 32 | Completion interrupt bit to wait on |
| irq_clear | output | 32 | Interrupt bits to clear before launch |

## Verification
The bench builds the block with LEN_W = 13, PAGE_W = 16 and ROW_BYTES = 2. A 13-bit length still holds a 2048-byte page plus spare plus a shifted spare column, and a two-byte row keeps the address-count field below its top value. With this small configuration the bench can sweep every combination of page size (512 and 2048), chip enable and DMA mode over the full opcode list. The sweep includes deferred pairs, confirms on a mismatched pending setup, confirms with nothing pending, and requests made while busy. Every case is compared with words computed arithmetically in the bench.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
   localparam logic [7:0] OP_READ0       = 8'h00;
   localparam logic [7:0] OP_READ1       = 8'h01;
   localparam logic [7:0] OP_RND_OUT     = 8'h05;
   localparam logic [7:0] OP_PROG_CONF   = 8'h10;
   localparam logic [7:0] OP_READ_CONF   = 8'h30;
   localparam logic [7:0] OP_SPARE_READ  = 8'h50;
   localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
   localparam logic [7:0] OP_STATUS      = 8'h70;
   localparam logic [7:0] OP_PROG_SETUP  = 8'h80;
   localparam logic [7:0] OP_IDENT       = 8'h90;
   localparam logic [7:0] OP_ERASE_CONF  = 8'hD0;
   localparam logic [7:0] OP_RND_CONF    = 8'hE0;

   localparam int B_VALID   = 31;
   localparam int B_ADDR_LO = 27;
   localparam int B_RD      = 26;
   localparam int B_WR      = 25;
   localparam int B_CE      = 19;
   localparam int S_ECC_GEN = 30;
   localparam int S_WIDE    = 29;
   localparam int S_RS      = 27;
   localparam int S_CONF    = 8;
   localparam int I_DONE    = 31;
   localparam int I_DMA     = 28;

   typedef struct packed {
      logic is_read;
      logic is_write;
      logic ident;
      logic read0;
      logic rnd;
      logic spare;
      logic defer;
      logic defer_prog;
      logic conf_prog;
      logic conf_erase;
   } op_class_t;
endpackage

// File: rtl/nand_op_decode.sv
module nand_op_decode
   import nand_seq_pkg::*;
(
   input  logic [7:0] op,
   output op_class_t  cls
);
   always_comb begin
      cls = '0;
      case (op)
         OP_READ0:       begin cls.is_read = 1'b1; cls.read0 = 1'b1; end
         OP_READ1:       cls.is_read = 1'b1;
         OP_RND_OUT:     begin cls.is_read = 1'b1; cls.rnd = 1'b1; end
         OP_SPARE_READ:  begin cls.is_read = 1'b1; cls.spare = 1'b1; end
         OP_IDENT,
         OP_STATUS:      begin cls.is_read = 1'b1; cls.ident = 1'b1; end
         OP_PROG_SETUP:  begin cls.is_write = 1'b1; cls.defer = 1'b1; cls.defer_prog = 1'b1; end
         OP_ERASE_SETUP: cls.defer = 1'b1;
         OP_PROG_CONF:   cls.conf_prog = 1'b1;
         OP_ERASE_CONF:  cls.conf_erase = 1'b1;
         default:        cls = '0;
      endcase
   end
endmodule

// File: rtl/nand_addr_len.sv
module nand_addr_len
   import nand_seq_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int ROW_BYTES = 3
) (
   input  op_class_t        cls,
   input  logic             wide,
   input  logic [LEN_W-1:0] column,
   input  logic             has_col,
   input  logic             has_page,
   input  logic [LEN_W-1:0] page_size,
   input  logic [LEN_W-1:0] spare_size,
   output logic [LEN_W-1:0] eff_col,
   output logic [2:0]       addr_bytes,
   output logic [LEN_W-1:0] len
);
   logic [2:0] col_b, row_b;

   always_comb begin
      eff_col    = (cls.spare && wide) ? column + page_size : column;
      col_b      = has_col ? (wide ? 3'd2 : 3'd1) : 3'd0;
      row_b      = has_page ? 3'(ROW_BYTES) : 3'd0;
      addr_bytes = cls.ident ? 3'd1 : col_b + row_b;
      if (cls.ident)
         len = LEN_W'(5);
      else if (cls.is_read || cls.is_write)
         len = page_size + spare_size - eff_col;
      else
         len = '0;
   end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
   import nand_seq_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int PAGE_W     = 24,
   parameter int ROW_BYTES  = 3,
   parameter int SMALL_PAGE = 512,
   parameter int WIDE_PAGE  = 2048,
   parameter bit RS_ECC     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [7:0]        req_opcode,
   input  logic [LEN_W-1:0]  req_column,
   input  logic              req_has_col,
   input  logic [PAGE_W-1:0] req_page,
   input  logic              req_has_page,
   input  logic [LEN_W-1:0]  page_size,
   input  logic [LEN_W-1:0]  spare_size,
   input  logic              chip_sel,
   input  logic              ecc_auto,
   input  logic              dma_en,
   input  logic              done_in,
   output logic              launch,
   output logic              busy,
   output logic [31:0]       cmd_word,
   output logic [31:0]       sec_word,
   output logic [LEN_W-1:0]  data_len,
   output logic [LEN_W-1:0]  xfer_col,
   output logic [PAGE_W-1:0] xfer_row,
   output logic              dma_valid,
   output logic [31:0]       dma_word,
   output logic [31:0]       irq_wait,
   output logic [31:0]       irq_clear
);
   localparam logic [31:0] DMA_BASE = 32'hC000_0000;
   localparam logic [31:0] IRQ_CLR  = (32'h1 << I_DONE) | (32'h1 << I_DMA);

   if (ROW_BYTES < 2 || ROW_BYTES > 3) begin : g_bad_row
      $error("ROW_BYTES must be 2 or 3");
   end
   if ((64'd1 << LEN_W) <= 64'(2 * WIDE_PAGE) || LEN_W > 30) begin : g_bad_len
      $error("LEN_W too small for a shifted spare column or above 30");
   end
   if (SMALL_PAGE >= WIDE_PAGE) begin : g_bad_page
      $error("SMALL_PAGE must be below WIDE_PAGE");
   end

   op_class_t        cls;
   logic             wide;
   logic [LEN_W-1:0] eff_col, new_len;
   logic [2:0]       abytes;
   logic             rs_bit;

   nand_op_decode u_dec (.op(req_opcode), .cls(cls));

   nand_addr_len #(.LEN_W(LEN_W), .ROW_BYTES(ROW_BYTES)) u_addr (
      .cls(cls), .wide(wide), .column(req_column), .has_col(req_has_col),
      .has_page(req_has_page), .page_size(page_size), .spare_size(spare_size),
      .eff_col(eff_col), .addr_bytes(abytes), .len(new_len));

   if (RS_ECC) begin : g_rs
      assign rs_bit = 1'b1;
   end else begin : g_no_rs
      assign rs_bit = 1'b0;
   end

   // deferred setup storage
   logic              pend_v, pend_prog;
   logic [31:0]       pend_cmd;
   logic [LEN_W-1:0]  pend_len, pend_col;
   logic [PAGE_W-1:0] pend_row;

   logic              accept, match, go, eff_read0, auto_v;
   logic [7:0]        eff_op, auto_op;
   logic [31:0]       base, new_cmd, sel_cmd, sel_sec, sel_dma, sel_wait;
   logic [LEN_W-1:0]  sel_len, sel_col;
   logic [PAGE_W-1:0] sel_row;
   logic              sel_dmav;

   assign req_ready = !busy;
   assign accept    = req_valid && !busy;
   assign wide      = page_size > LEN_W'(SMALL_PAGE);

   always_comb begin
      base            = '0;
      base[S_RS]      = rs_bit;
      base[S_WIDE]    = page_size == LEN_W'(WIDE_PAGE);
      eff_read0       = cls.read0 || (cls.spare && wide);
      eff_op          = (cls.spare && wide) ? OP_READ0 : req_opcode;
      auto_v          = cls.rnd || (eff_read0 && wide);
      auto_op         = cls.rnd ? OP_RND_CONF : OP_READ_CONF;

      new_cmd         = '0;
      new_cmd[B_VALID] = 1'b1;
      new_cmd[7:0]    = eff_op;
      new_cmd[B_CE]   = chip_sel;
      new_cmd[B_RD]   = cls.is_read;
      new_cmd[B_WR]   = cls.is_write;
      if (abytes != 3'd0)
         new_cmd[B_ADDR_LO+3:B_ADDR_LO] = {1'b1, abytes - 3'd1};

      match = pend_v && ((cls.conf_prog && pend_prog) || (cls.conf_erase && !pend_prog));
      go    = accept && (match || !cls.defer);

      if (match) begin
         sel_cmd = pend_cmd;
         sel_len = pend_len;
         sel_col = pend_col;
         sel_row = pend_row;
         sel_sec = base | (32'h1 << S_CONF) | 32'(req_opcode);
         sel_sec[S_ECC_GEN] = cls.conf_prog && ecc_auto;
      end else begin
         sel_cmd = new_cmd;
         sel_len = new_len;
         sel_col = eff_col;
         sel_row = req_page;
         sel_sec = auto_v ? (base | (32'h1 << S_CONF) | 32'(auto_op)) : 32'h0;
      end

      sel_dmav = dma_en && (sel_cmd[B_RD] || sel_cmd[B_WR]);
      sel_dma  = sel_dmav ? DMA_BASE + 32'(sel_len) : 32'h0;
      sel_wait = (dma_en && sel_cmd[B_RD]) ? (32'h1 << I_DMA) : (32'h1 << I_DONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         launch    <= 1'b0;
         busy      <= 1'b0;
         cmd_word  <= '0;
         sec_word  <= '0;
         data_len  <= '0;
         xfer_col  <= '0;
         xfer_row  <= '0;
         dma_valid <= 1'b0;
         dma_word  <= '0;
         irq_wait  <= '0;
         irq_clear <= '0;
         pend_v    <= 1'b0;
         pend_prog <= 1'b0;
         pend_cmd  <= '0;
         pend_len  <= '0;
         pend_col  <= '0;
         pend_row  <= '0;
      end else begin
         launch    <= go;
         irq_clear <= go ? IRQ_CLR : 32'h0;
         if (go) begin
            busy      <= 1'b1;
            cmd_word  <= sel_cmd;
            sec_word  <= sel_sec;
            data_len  <= sel_len;
            xfer_col  <= sel_col;
            xfer_row  <= sel_row;
            dma_valid <= sel_dmav;
            dma_word  <= sel_dma;
            irq_wait  <= sel_wait;
         end else if (busy && done_in) begin
            busy <= 1'b0;
         end
         if (accept) begin
            if (cls.defer) begin
               pend_v    <= 1'b1;
               pend_prog <= cls.defer_prog;
               pend_cmd  <= new_cmd;
               pend_len  <= new_len;
               pend_col  <= eff_col;
               pend_row  <= req_page;
            end else begin
               pend_v <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
   parameter int LEN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done_in,
   input logic             launch,
   input logic             busy,
   input logic [31:0]      cmd_word,
   input logic [31:0]      sec_word,
   input logic [LEN_W-1:0] data_len,
   input logic             dma_valid,
   input logic [31:0]      dma_word,
   input logic [31:0]      irq_wait
);
   a_r12_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> busy);
   a_r12_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done_in |=> busy);
   a_r12_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !launch);
   a_r2_valid_flag: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> cmd_word[31]);
   a_r3_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !(cmd_word[26] && cmd_word[25]));
   a_r9_write_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
      launch && cmd_word[25] |-> sec_word[8] && sec_word[7:0] == 8'h10);
   a_r11_dma_word: assert property (@(posedge clk) disable iff (!rst_n)
      launch && dma_valid |-> dma_word == 32'hC000_0000 + 32'(data_len));
   a_r11_wait_single: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> $countones(irq_wait) == 1);
endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(.LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .done_in(done_in), .launch(launch), .busy(busy),
   .cmd_word(cmd_word), .sec_word(sec_word), .data_len(data_len),
   .dma_valid(dma_valid), .dma_word(dma_word), .irq_wait(irq_wait));

// File: tb/test_nand_cmd_seq.sv
module test_nand_cmd_seq;
   localparam int LEN_W = 13;
   localparam int PAGE_W = 16;
   localparam int ROWB = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [7:0] req_opcode = '0;
   logic [LEN_W-1:0] req_column = '0;
   logic req_has_col = 1'b0, req_has_page = 1'b0;
   logic [PAGE_W-1:0] req_page = '0;
   logic [LEN_W-1:0] page_size = LEN_W'(512), spare_size = LEN_W'(16);
   logic chip_sel = 1'b0, ecc_auto = 1'b0, dma_en = 1'b0, done_in = 1'b0;
   logic launch, busy, dma_valid;
   logic [31:0] cmd_word, sec_word, dma_word, irq_wait, irq_clear;
   logic [LEN_W-1:0] data_len, xfer_col;
   logic [PAGE_W-1:0] xfer_row;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   nand_cmd_seq #(.LEN_W(LEN_W), .PAGE_W(PAGE_W), .ROW_BYTES(ROWB)) i_nand_cmd_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_opcode(req_opcode), .req_column(req_column), .req_has_col(req_has_col),
      .req_page(req_page), .req_has_page(req_has_page), .page_size(page_size),
      .spare_size(spare_size), .chip_sel(chip_sel), .ecc_auto(ecc_auto),
      .dma_en(dma_en), .done_in(done_in), .launch(launch), .busy(busy),
      .cmd_word(cmd_word), .sec_word(sec_word), .data_len(data_len),
      .xfer_col(xfer_col), .xfer_row(xfer_row), .dma_valid(dma_valid),
      .dma_word(dma_word), .irq_wait(irq_wait), .irq_clear(irq_clear));

   // bench-side expectations
   logic [31:0] e_cmd, e_sec;
   logic [LEN_W-1:0] e_len, e_col;
   logic [PAGE_W-1:0] e_row;
   logic bp_v = 1'b0, bp_prog = 1'b0;
   logic [31:0] bp_cmd = '0;
   logic [LEN_W-1:0] bp_len = '0, bp_col = '0;
   logic [PAGE_W-1:0] bp_row = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] base_word();
      return (32'h1 << 27) | ((page_size == LEN_W'(2048)) ? (32'h1 << 29) : 32'h0);
   endfunction

   // plain command expectation from R2..R8
   task automatic model(input logic [7:0] op, input int col, input bit hc, input bit hp,
                        input logic [PAGE_W-1:0] row);
      bit wide, rd, wr, ident, spare;
      int ab, ecol, len;
      logic [7:0] eop;
      wide  = page_size > LEN_W'(512);
      ident = (op == 8'h90) || (op == 8'h70);
      rd    = (op == 8'h00) || (op == 8'h01) || (op == 8'h05) || (op == 8'h50) || ident;
      wr    = (op == 8'h80);
      spare = (op == 8'h50) && wide;
      eop   = spare ? 8'h00 : op;
      ecol  = spare ? col + int'(page_size) : col;
      ab    = ident ? 1 : ((hc ? (wide ? 2 : 1) : 0) + (hp ? ROWB : 0));
      len   = ident ? 5 : ((rd || wr) ? int'(page_size) + int'(spare_size) - ecol : 0);
      e_cmd = 32'h8000_0000 | 32'(eop) | (32'(chip_sel) << 19) | (32'(rd) << 26) | (32'(wr) << 25);
      if (ab != 0) e_cmd = e_cmd | ((32'h8 | 32'(ab - 1)) << 27);
      e_len = LEN_W'(len);
      e_col = LEN_W'(ecol);
      e_row = row;
      if (op == 8'h05) e_sec = base_word() | 32'h100 | 32'hE0;
      else if (eop == 8'h00 && wide) e_sec = base_word() | 32'h100 | 32'h30;
      else e_sec = 32'h0;
   endtask

   task automatic run(input logic [7:0] op, input int col, input bit hc, input bit hp,
                      input logic [PAGE_W-1:0] row);
      bit match, defer, rd, wr;
      string tag;
      defer = (op == 8'h80) || (op == 8'h60);
      match = bp_v && ((op == 8'h10 && bp_prog) || (op == 8'hD0 && !bp_prog));
      if (match) begin
         e_cmd = bp_cmd; e_len = bp_len; e_col = bp_col; e_row = bp_row;
         e_sec = base_word() | 32'h100 | 32'(op) | ((op == 8'h10 && ecc_auto) ? (32'h1 << 30) : 32'h0);
         tag = "R9";
      end else begin
         model(op, col, hc, hp, row);
         tag = (op == 8'h10 || op == 8'hD0) ? "R10" : (op == 8'h50) ? "R7" :
               (op == 8'h90 || op == 8'h70) ? "R5" : "R2 R3 R4 R6 R8";
      end
      @(negedge clk);
      req_opcode = op; req_column = LEN_W'(col); req_has_col = hc; req_has_page = hp;
      req_page = row; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (defer && !match) begin
         chk("R9 setup not launched", {31'h0, launch}, 32'h0);
         chk("R9 idle after setup", {31'h0, busy}, 32'h0);
         bp_v = 1'b1; bp_prog = (op == 8'h80);
         bp_cmd = e_cmd; bp_len = e_len; bp_col = e_col; bp_row = e_row;
         return;
      end
      bp_v = 1'b0;
      rd = e_cmd[26]; wr = e_cmd[25];
      chk({tag, " launch"}, {31'h0, launch}, 32'h1);
      chk({tag, " cmd_word"}, cmd_word, e_cmd);
      chk({tag, " sec_word"}, sec_word, e_sec);
      chk({tag, " data_len"}, 32'(data_len), 32'(e_len));
      chk({tag, " xfer_col"}, 32'(xfer_col), 32'(e_col));
      chk({tag, " xfer_row"}, 32'(xfer_row), 32'(e_row));
      chk("R11 dma_valid", {31'h0, dma_valid}, {31'h0, dma_en && (rd || wr)});
      chk("R11 dma_word", dma_word, (dma_en && (rd || wr)) ? 32'hC000_0000 + 32'(e_len) : 32'h0);
      chk("R11 irq_wait", irq_wait, (dma_en && rd) ? 32'h1000_0000 : 32'h8000_0000);
      chk("R11 irq_clear", irq_clear, 32'h9000_0000);
      chk("R12 busy", {30'h0, busy, req_ready}, 32'h2);
      done_in = 1'b1;
      @(negedge clk);
      done_in = 1'b0;
      chk("R12 ready after done", {30'h0, busy, req_ready}, 32'h1);
   endtask

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 launch/busy/ready", {29'h0, launch, busy, req_ready}, 32'h1);
      chk("R1 cmd_word", cmd_word, 32'h0);
      chk("R1 sec_word", sec_word, 32'h0);
      chk("R1 dma", {dma_word[31:1], dma_valid}, 32'h0);
      chk("R1 len", 32'(data_len), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int ps = 0; ps < 2; ps++) begin
         for (int cs = 0; cs < 2; cs++) begin
            for (int dm = 0; dm < 2; dm++) begin
               page_size  = ps ? LEN_W'(2048) : LEN_W'(512);
               spare_size = ps ? LEN_W'(64) : LEN_W'(16);
               chip_sel   = cs[0];
               dma_en     = dm[0];
               ecc_auto   = cs[0] ^ dm[0];
               run(8'h00, 0, 1, 1, 16'h1234);
               run(8'h00, 7, 1, 1, 16'h0042);
               run(8'h01, 3, 1, 1, 16'h00AA);
               run(8'h50, 3, 1, 1, 16'h0101);   // R7 on wide pages
               run(8'h05, 100, 1, 0, 16'h0);    // R8 random-out confirm
               run(8'h90, 0, 1, 0, 16'h0);      // R5
               run(8'h70, 0, 0, 0, 16'h0);      // R5 status still one cycle
               run(8'h60, 0, 0, 1, 16'h0BEE);   // R9 erase pair
               run(8'hD0, 0, 0, 0, 16'h0);
               run(8'h80, 0, 1, 1, 16'h0777);   // R9 program pair
               run(8'h10, 0, 0, 0, 16'h0);
               run(8'h80, 5, 1, 1, 16'h0300);   // R10 discarded by a read
               run(8'h00, 0, 1, 1, 16'h0301);
               run(8'h10, 0, 0, 0, 16'h0);      // R10 confirm with nothing pending
               run(8'h60, 0, 0, 1, 16'h0500);   // R10 wrong confirm discards
               run(8'h10, 0, 0, 0, 16'h0);
               run(8'hD0, 0, 0, 0, 16'h0);
               run(8'hFF, 0, 0, 0, 16'h0);
            end
         end
      end

      // R12: a request while busy is ignored
      page_size = LEN_W'(2048); spare_size = LEN_W'(64); dma_en = 1'b0; chip_sel = 1'b0;
      @(negedge clk);
      req_opcode = 8'h70; req_has_col = 1'b0; req_has_page = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R12 status launched", {31'h0, launch}, 32'h1);
      req_opcode = 8'h00; req_has_col = 1'b1; req_has_page = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R12 no launch while busy", {31'h0, launch}, 32'h0);
      chk("R12 word unchanged while busy", cmd_word, 32'h8000_0070 | (32'h8 << 27) | (32'h1 << 26));
      chk("R12 still busy", {31'h0, busy}, 32'h1);
      done_in = 1'b1;
      @(negedge clk);
      done_in = 1'b0;
      chk("R12 released", {31'h0, req_ready}, 32'h1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule